// File: doc/BRIEF.md
# UART receiver with line status

This block turns an asynchronous serial line into characters and holds them in a receive queue for a host to read. The line is sampled on an enable pulse that arrives sixteen times per bit. Each character can be five to eight data bits long, least significant bit first, and may be followed by an optional even or odd parity bit and one stop bit. Every stored character carries two tags: one for a parity mismatch and one for a low stop bit. The status flags show these tags only while that character is the oldest one held.

The host reads through a single strobe with a select. One select value returns the oldest character and removes it. The other returns a status byte and clears the error flags. The queue runs either as a sixteen-entry FIFO or as a single holding register, and the two modes handle a character that arrives with no room in different ways. After a low stop bit, the receiver takes that low level as the start bit of the next character and goes straight on to its data bits.

Top module: `uart_rx_lsr`

## Requirements
- R1: A bit lasts 16 `sample_tick` pulses. A falling edge starts a character only if the line is still low 8 ticks later. A low pulse shorter than that stores nothing.
- R2: The data length is `word_len` + 5 bits (0 gives 5 bits, 3 gives 8 bits), received least significant bit first. Buffer reads return the character right-aligned, with unused upper bits read as 0.
- R3: With `par_en` high, a parity bit follows the data. `par_even` = 1 requires an even count of ones over data plus parity, and 0 requires an odd count. A mismatch tags the character. With `par_en` low, no parity bit is expected and the parity tag is never set.
- R4: A stop-position sample of 0 tags the character with a framing error. The character is still stored.
- R5: After a framing error, the low stop level counts as the next start bit. If it is still low on the following tick, the data bits are shifted in 16 ticks after the stop sample, with no new falling edge needed.
- R6: The status byte has ready in bit 0, overrun in bit 1, parity error in bit 2 and framing error in bit 3; bits 7:4 read as 0. Bits 2 and 3 reflect only the tags of the oldest held character.
- R7: A status read clears the overrun flag and the oldest character's tags. An overrun or character that arrives in the same cycle as the read takes priority.
- R8: With `fifo_en` high, up to 16 characters are held and each buffer read removes the oldest. A character completed while 16 are held is discarded, the held ones are kept, and overrun is set.
- R9: With `fifo_en` low, one character is held. A new character replaces an unread one and sets overrun.
- R10: Ready is high exactly while at least one character is held. A buffer read with nothing held returns 0 and changes nothing.
- R11: After reset, nothing is held and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| rd_stb | input | 1 | Read strobe, one cycle |
| rd_sel | input | 1 | 0 = receive buffer, 1 = status |
| rd_data | output | 8 | Read data for the current select |
| st_ready | output | 1 | Character available |
| st_overrun | output | 1 | Character lost |
| st_parity | output | 1 | Oldest character has a parity error |
| st_frame | output | 1 | Oldest character has a framing error |

## Verification
The hardest state to reach is the resynchronisation path. It only exists when a character's stop bit is held low for its full length and the next character's data bits follow with no idle gap and no start edge of their own. The stimulus builds this line pattern bit by bit. It then checks that the first character carries only the framing tag and that the second arrives intact and untagged. The full-queue overrun is reached by sending seventeen characters with no reads in between. The check then confirms that the first sixteen come back unchanged.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;
    localparam int BIT_IW = $clog2(CHAR_W);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_RESYNC
    } rx_state_e;

    // Entry layout: character, parity tag, framing tag (bit 0)
    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rxd,
    input  logic [1:0] word_len,
    input  logic     par_en,
    input  logic     par_even,
    output logic     out_valid,
    output rx_char_t out_char
);

    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2 - 1;

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [BIT_IW-1:0] bit_idx;
        logic [CHAR_W-1:0] shift;
        logic              pbit;
    } deser_t;

    deser_t q, d;
    logic [CHAR_W-1:0] aligned;
    logic              last_bit;

    always_comb begin
        d         = q;
        out_valid = 1'b0;
        aligned   = q.shift >> (2'd3 - word_len);
        last_bit  = (q.bit_idx == {1'b1, word_len});
        out_char.data    = aligned;
        out_char.par_err = par_en & (^aligned ^ q.pbit ^ ~par_even);
        out_char.frm_err = ~rxd;
        if (tick) begin
            unique case (q.st)
                RX_IDLE: begin
                    if (!rxd) begin
                        d.st  = RX_START;
                        d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (q.cnt == CW'(MID)) begin
                        d.st      = rxd ? RX_IDLE : RX_DATA;
                        d.cnt     = '0;
                        d.bit_idx = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.cnt == CW'(OSR - 1)) begin
                        d.shift = {rxd, q.shift[CHAR_W-1:1]};
                        d.cnt   = '0;
                        if (last_bit) d.st = par_en ? RX_PAR : RX_STOP;
                        else          d.bit_idx = q.bit_idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (q.cnt == CW'(OSR - 1)) begin
                        d.pbit = rxd;
                        d.st   = RX_STOP;
                        d.cnt  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.cnt == CW'(OSR - 1)) begin
                        out_valid = 1'b1;
                        d.st      = rxd ? RX_IDLE : RX_RESYNC;
                        d.cnt     = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_RESYNC: begin
                    // second look at the low stop level, now a start bit
                    if (!rxd) begin
                        d.st      = RX_DATA;
                        d.cnt     = CW'(1);
                        d.bit_idx = '0;
                    end else begin
                        d.st = RX_IDLE;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, default: '0};
        else        q <= d;
    end

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 10,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               single_mode,
    input  logic               push,
    input  logic [ENTRY_W-1:0] wentry,
    input  logic               pop,
    input  logic               clr_tags,
    output logic [ENTRY_W-1:0] head,
    output logic [CNT_W-1:0]   fill,
    output logic               lost
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][ENTRY_W-1:0] mem;
        logic [PW-1:0]                 rd;
        logic [PW-1:0]                 wr;
        logic [CNT_W-1:0]              cnt;
    } store_t;

    store_t q, d;
    logic [CNT_W-1:0] cnt_mid, cap;
    logic             do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d      = q;
        lost   = 1'b0;
        do_pop = pop && (q.cnt != '0);
        cap    = single_mode ? CNT_W'(1) : CNT_W'(DEPTH);
        if (clr_tags && (q.cnt != '0)) d.mem[q.rd][1:0] = 2'b00;
        if (do_pop) d.rd = ptr_inc(q.rd);
        cnt_mid = q.cnt - CNT_W'(do_pop);
        d.cnt   = cnt_mid;
        if (push) begin
            if (cnt_mid < cap) begin
                d.mem[q.wr] = wentry;
                d.wr        = ptr_inc(q.wr);
                d.cnt       = cnt_mid + 1'b1;
            end else if (single_mode) begin
                d.mem[q.rd] = wentry;
                lost        = 1'b1;
            end else begin
                lost = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head = q.mem[q.rd];
    assign fill = q.cnt;

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick,
    input  logic       rxd,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       fifo_en,
    input  logic       rd_stb,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    output logic       st_ready,
    output logic       st_overrun,
    output logic       st_parity,
    output logic       st_frame
);

    localparam int ENTRY_W = CHAR_W + 2;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    typedef struct packed {
        logic ovr;
    } stat_t;

    stat_t              q, d;
    rx_char_t           ch;
    logic               ch_valid;
    logic [ENTRY_W-1:0] head;
    logic [CNT_W-1:0]   fill;
    logic               lost;
    logic               lsr_rd;
    logic               rbr_rd;

    assign lsr_rd = rd_stb & rd_sel;
    assign rbr_rd = rd_stb & ~rd_sel;

    uart_rx_deser #(.OSR(OSR)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .rxd       (rxd),
        .word_len  (word_len),
        .par_en    (par_en),
        .par_even  (par_even),
        .out_valid (ch_valid),
        .out_char  (ch)
    );

    uart_rx_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .single_mode (~fifo_en),
        .push        (ch_valid),
        .wentry      (ch),
        .pop         (rbr_rd),
        .clr_tags    (lsr_rd),
        .head        (head),
        .fill        (fill),
        .lost        (lost)
    );

    always_comb begin
        d     = q;
        d.ovr = lost | (q.ovr & ~lsr_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st_ready   = (fill != '0);
    assign st_overrun = q.ovr;
    assign st_parity  = st_ready & head[1];
    assign st_frame   = st_ready & head[0];

    always_comb begin
        if (rd_sel)        rd_data = {4'b0000, st_frame, st_parity, st_overrun, st_ready};
        else if (st_ready) rd_data = head[ENTRY_W-1:2];
        else               rd_data = '0;
    end

endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_stb,
    input logic             rd_sel,
    input logic             par_en,
    input logic             push,
    input logic             lost,
    input logic [CNT_W-1:0] fill,
    input logic             st_ready,
    input logic             st_overrun,
    input logic             st_parity,
    input logic             st_frame
);

    // R10
    push_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> st_ready);

    // R10
    last_read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !rd_sel && fill == CNT_W'(1) && !push) |=> !st_ready);

    // R7
    status_read_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel && !lost) |=> !st_overrun);

    // R7
    status_read_clears_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel && !push) |=> (!st_parity && !st_frame));

    // R8
    lost_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> st_overrun);

    // R8
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R3
    no_parity_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_ready) && !par_en && $stable(par_en)) |-> !st_parity);

endmodule

bind uart_rx_lsr uart_rx_lsr_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .rd_sel     (rd_sel),
    .par_en     (par_en),
    .push       (ch_valid),
    .lost       (lost),
    .fill       (fill),
    .st_ready   (st_ready),
    .st_overrun (st_overrun),
    .st_parity  (st_parity),
    .st_frame   (st_frame)
);

// File: tb/tb_uart_rx_lsr.sv
module tb_uart_rx_lsr;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;   // 16 ticks, one tick every 2 clocks
    localparam int QDEPTH     = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_even = 1'b1;
    logic       fifo_en = 1'b1;
    logic       rd_stb = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       st_ready, st_overrun, st_parity, st_frame;

    int checks = 0;
    int failures = 0;

    logic [9:0] mq[$];   // {data, parity tag, framing tag}
    logic       m_ovr = 1'b0;

    uart_rx_lsr dut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
        .word_len(word_len), .par_en(par_en), .par_even(par_even),
        .fifo_en(fifo_en), .rd_stb(rd_stb), .rd_sel(rd_sel),
        .rd_data(rd_data), .st_ready(st_ready), .st_overrun(st_overrun),
        .st_parity(st_parity), .st_frame(st_frame)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial forever begin
        @(negedge clk);
        sample_tick = ~sample_tick;
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete act=hung exp=done");
        finish_run();
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_len(input logic [7:0] v, input logic [1:0] wl);
        return v & (8'hFF >> (2'd3 - wl));
    endfunction

    function automatic logic good_parity(input logic [7:0] v, input logic even);
        return even ? ^v : ~^v;
    endfunction

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_data_bits(input logic [7:0] v, input logic [1:0] wl);
        for (int i = 0; i < 5 + int'(wl); i++) drive_bit(v[i]);
    endtask

    task automatic send_char(input logic [7:0] v, input logic flip_par, input logic stopv);
        drive_bit(1'b0);
        send_data_bits(v, word_len);
        if (par_en) drive_bit(good_parity(mask_len(v, word_len), par_even) ^ flip_par);
        drive_bit(stopv);
    endtask

    function automatic void model_push(input logic [7:0] v, input logic perr, input logic ferr);
        logic [9:0] e;
        e = {mask_len(v, word_len), perr & par_en, ferr};
        if (fifo_en) begin
            if (mq.size() == QDEPTH) m_ovr = 1'b1;
            else mq.push_back(e);
        end else begin
            if (mq.size() == 1) begin
                mq[0] = e;
                m_ovr = 1'b1;
            end else mq.push_back(e);
        end
    endfunction

    task automatic read_reg(input logic sel, output logic [7:0] val);
        @(negedge clk);
        rd_sel = sel;
        rd_stb = 1'b1;
        #1 val = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic read_status(input string req);
        logic [7:0] v, exp;
        logic rdy, pe, fe;
        rdy = (mq.size() != 0);
        pe  = rdy ? mq[0][1] : 1'b0;
        fe  = rdy ? mq[0][0] : 1'b0;
        exp = {4'b0000, fe, pe, m_ovr, rdy};
        read_reg(1'b1, v);
        check(req, v, exp);
        m_ovr = 1'b0;
        if (rdy) mq[0][1:0] = 2'b00;
    endtask

    task automatic read_buf(input string req);
        logic [7:0] v, exp;
        exp = (mq.size() != 0) ? mq[0][9:2] : 8'h00;
        read_reg(1'b0, v);
        check(req, v, exp);
        if (mq.size() != 0) void'(mq.pop_front());
    endtask

    initial begin
        logic [7:0] v;
        logic       fp;
        void'($urandom(32'h5A17C3));
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11 status at reset", {4'b0, st_frame, st_parity, st_overrun, st_ready}, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        read_status("R11 status after reset");
        read_buf("R10 empty buffer read returns 0");

        // R2 / R10: plain 8-bit character
        word_len = 2'd3; par_en = 1'b0;
        send_char(8'hA5, 1'b0, 1'b1);
        model_push(8'hA5, 1'b0, 1'b0);
        read_status("R10 ready after one char");
        read_buf("R2 8-bit data");
        read_status("R10 ready clears when drained");

        // R1: short low glitch is not a start bit
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        read_status("R1 glitch rejected");

        // R3 / R7: 7 bits, even parity, wrong parity bit
        word_len = 2'd2; par_en = 1'b1; par_even = 1'b1;
        send_char(8'h3B, 1'b1, 1'b1);
        model_push(8'h3B, 1'b1, 1'b0);
        read_status("R3 parity error flagged");
        read_status("R7 status read cleared parity");
        read_buf("R2 7-bit data after parity error");

        // R6: tags shown only for the oldest character
        par_even = 1'b0;
        send_char(8'h11, 1'b0, 1'b1);
        model_push(8'h11, 1'b0, 1'b0);
        send_char(8'h6E, 1'b1, 1'b1);
        model_push(8'h6E, 1'b1, 1'b0);
        read_status("R6 head clean, later char tagged");
        read_buf("R6 first char");
        read_status("R6 tag appears at head");
        read_buf("R6 second char");

        // R4 / R5: low stop bit, next data follows without start edge
        word_len = 2'd3; par_en = 1'b0;
        send_char(8'h3C, 1'b0, 1'b0);
        send_data_bits(8'h5A, 2'd3);
        drive_bit(1'b1);
        repeat (BIT_CLKS) @(negedge clk);
        model_push(8'h3C, 1'b0, 1'b1);
        model_push(8'h5A, 1'b0, 1'b0);
        read_status("R4 framing error flagged");
        read_buf("R4 framed char still stored");
        read_status("R5 resynced char clean");
        read_buf("R5 resynced char data");

        // R8: 17 characters into a 16-entry queue
        word_len = 2'd0; par_en = 1'b0;
        for (int i = 0; i < QDEPTH + 1; i++) begin
            v = 8'(i * 3 + 1);
            send_char(v, 1'b0, 1'b1);
            model_push(v, 1'b0, 1'b0);
        end
        read_status("R8 overrun on full queue");
        read_status("R7 overrun cleared by status read");
        for (int i = 0; i < QDEPTH; i++) read_buf("R8 queue contents kept");
        read_status("R10 empty after draining");

        // R9: single holding register
        fifo_en = 1'b0; word_len = 2'd1;
        send_char(8'h15, 1'b0, 1'b1);
        model_push(8'h15, 1'b0, 1'b0);
        send_char(8'h2A, 1'b0, 1'b1);
        model_push(8'h2A, 1'b0, 1'b0);
        read_status("R9 overrun in holding mode");
        read_buf("R9 newest char kept");
        read_status("R9 holding register empty");
        fifo_en = 1'b1;

        // Random traffic: R2, R3, R6, R10
        for (int n = 0; n < 30; n++) begin
            word_len = 2'($urandom_range(0, 3));
            par_en   = 1'($urandom_range(0, 1));
            par_even = 1'($urandom_range(0, 1));
            v        = 8'($urandom);
            fp       = ($urandom_range(0, 3) == 0);
            send_char(v, fp, 1'b1);
            model_push(v, fp, 1'b0);
            if ($urandom_range(0, 2) == 0) begin
                while (mq.size() != 0) begin
                    read_status("R3 random status");
                    read_buf("R2 random data");
                end
            end
        end
        while (mq.size() != 0) begin
            read_status("R6 random status drain");
            read_buf("R2 random data drain");
        end
        read_status("R10 final empty");
        finish_run();
    end

endmodule